// File: doc/BRIEF.md
# Unrolled Pipelined CORDIC Sine/Cosine Generator

This block turns a signed fixed-point angle into its sine and cosine with a rotation-mode CORDIC. The iterations are laid out in space, not in time. Each iteration is its own stage, and every stage has a fixed shift amount and a fixed arctangent constant. The x, y and z words leave one stage and go straight into the next. No stage hardware is reused and no iteration counter exists.

A parameter sets how many stages sit between banks of pipeline registers. At one extreme there is a register after every stage. At the other the datapath is purely combinational. This lets the same source be tuned for clock rate or for register count. A valid flag travels through the same banks as the data. Once the pipeline is full, the block takes a new angle and delivers one result on every clock, with no handshake.

The x path starts at the reciprocal of the CORDIC gain and the y path starts at zero, so the outputs need no final scaling. The angle code maps ±π onto the full 16-bit signed range. Only codes within ±π/2 are supported.

Top module: `cordic_sine_unrolled`

## Requirements
- R1: `rst_n` is a synchronous, active-low reset. It clears every valid flag in the pipeline. `out_valid` is low from the first clock edge with `rst_n` low until a strobe given after reset has crossed the pipeline. A strobe given while `rst_n` is low never produces a result.
- R2: A new angle is accepted on every clock with `in_valid` high, back to back, with no stall. Each accepted angle yields exactly one result.
- R3: The latency in clocks equals the number of register banks. That number is ceil(ITER/STAGES_PER_REG) when STAGES_PER_REG ≤ ITER, and 0 otherwise. `out_valid` is `in_valid` delayed by exactly that latency.
- R4: Angle code a stands for θ = a·π/32768 and is valid for −16384 ≤ a ≤ 16384. `out_sin` is signed Q1.14 (16384 means 1.0) and lies within ±10 LSB of sin θ.
- R5: `out_cos` is signed Q1.14 and lies within ±10 LSB of cos θ for the same angle range.
- R6: Whenever `out_valid` is high, out_sin² + out_cos² lies strictly between 2^28 − 2^20 and 2^28 + 2^20.
- R7: At the range ends, a = +16384 gives out_sin ≈ +16384 and a = −16384 gives out_sin ≈ −16384, with out_cos ≈ 0 in both cases (tolerance as in R4 and R5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Strobe that marks `in_angle` as a new sample |
| in_angle | input | 16 | Signed angle code, ±π full scale |
| out_valid | output | 1 | Result strobe, `in_valid` delayed by the latency |
| out_sin | output | 16 | Sine, signed Q1.14 |
| out_cos | output | 16 | Cosine, signed Q1.14 |

## Verification
Two things overlap here. In any cycle of a stream, a new angle enters stage zero while an older angle's result leaves the last bank. A reset can also land while the pipeline is full and the strobe is still high. The bench streams angles back to back and with random gaps, and compares each result against a real-valued sine and cosine of the angle given exactly the latency earlier. It also asserts reset in the middle of a stream and expects `out_valid` to stay low until a fresh post-reset strobe has crossed the pipeline, with no leftover result from before the reset.

// File: rtl/cordic_pkg.sv
// Package: shared word type, lane bundle and hardwired constants for the
// unrolled CORDIC. Assumes angle codes map +/-pi onto the full signed word.
package cordic_pkg;
    localparam int WORD = 16;
    localparam int FRAC = 14;

    typedef logic signed [WORD-1:0] word_t;

    // One lane between stages: valid flag plus the three rotation words.
    typedef struct packed {
        logic  vld;
        word_t x;
        word_t y;
        word_t z;
    } lane_t;

    // Reciprocal of the CORDIC gain in Q1.14.
    localparam word_t INV_GAIN = 16'sd9949;

    // atan(2^-i) scaled so that pi maps to 32768.
    function automatic word_t atan_code(input int i);
        case (i)
            0:       return 16'sd8192;
            1:       return 16'sd4836;
            2:       return 16'sd2555;
            3:       return 16'sd1297;
            4:       return 16'sd651;
            5:       return 16'sd326;
            6:       return 16'sd163;
            7:       return 16'sd81;
            8:       return 16'sd41;
            9:       return 16'sd20;
            10:      return 16'sd10;
            11:      return 16'sd5;
            12:      return 16'sd3;
            13:      return 16'sd1;
            14:      return 16'sd1;
            default: return 16'sd0;
        endcase
    endfunction
endpackage

// File: rtl/cordic_stage.sv
// Module: one combinational CORDIC micro-rotation with a wired shift and a
// hardwired arctangent. Assumes shifts are arithmetic (sign kept).
module cordic_stage
    import cordic_pkg::*;
#(
    parameter int    SHIFT = 0,
    parameter word_t ATAN  = '0
) (
    input  lane_t a,
    output lane_t b
);
    word_t xs;
    word_t ys;

    // Rotate toward zero residual angle; the sign of z picks the direction.
    always_comb begin
        xs    = a.x >>> SHIFT;
        ys    = a.y >>> SHIFT;
        b.vld = a.vld;
        if (a.z[WORD-1]) begin
            b.x = a.x + ys;
            b.y = a.y - xs;
            b.z = a.z + ATAN;
        end else begin
            b.x = a.x - ys;
            b.y = a.y + xs;
            b.z = a.z - ATAN;
        end
    end
endmodule

// File: rtl/cordic_bank.sv
// Module: optional register bank between stages. ENABLE=0 is a plain wire.
// Assumes a synchronous active-low reset that clears the lane.
module cordic_bank
    import cordic_pkg::*;
#(
    parameter bit ENABLE = 1'b1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  lane_t d,
    output lane_t q
);
    generate
        if (ENABLE) begin : g_reg
            // Capture the lane each clock; reset drops the valid flag.
            always_ff @(posedge clk) begin
                if (!rst_n) q <= '0;
                else        q <= d;
            end

            // R1: a bank holds no valid sample on the edge after reset.
            a_r1_bank_clear: assert property (@(posedge clk)
                !rst_n |=> !q.vld);
        end else begin : g_wire
            assign q = d;
        end
    endgenerate
endmodule

// File: rtl/cordic_sine_unrolled.sv
// Module: fully unrolled rotation-mode CORDIC with register banks every
// STAGES_PER_REG stages. Assumes inputs lie within +/-pi/2 (code +/-16384).
module cordic_sine_unrolled
    import cordic_pkg::*;
#(
    parameter int ITER           = 14,
    parameter int STAGES_PER_REG = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic signed [WORD-1:0] in_angle,
    output logic                   out_valid,
    output logic signed [WORD-1:0] out_sin,
    output logic signed [WORD-1:0] out_cos
);
    localparam int BANKS = (STAGES_PER_REG > ITER) ? 0
                         : (ITER + STAGES_PER_REG - 1) / STAGES_PER_REG;

    lane_t chain [0:ITER];

    // Seed the first stage with the pre-scaled unit vector.
    assign chain[0] = '{vld: in_valid, x: INV_GAIN, y: '0, z: in_angle};

    generate
        for (genvar s = 0; s < ITER; s++) begin : g_stage
            localparam bit REG_HERE = ((s + 1) % STAGES_PER_REG == 0) ||
                                      ((s == ITER - 1) && (STAGES_PER_REG <= ITER));
            lane_t mid;

            cordic_stage #(.SHIFT(s), .ATAN(atan_code(s))) u_rot (
                .a (chain[s]),
                .b (mid)
            );

            cordic_bank #(.ENABLE(REG_HERE)) u_bank (
                .clk   (clk),
                .rst_n (rst_n),
                .d     (mid),
                .q     (chain[s+1])
            );
        end
    endgenerate

    assign out_valid = chain[ITER].vld;
    assign out_sin   = chain[ITER].y;
    assign out_cos   = chain[ITER].x;

    // ---------------- assertions ----------------
    logic [7:0]         inflight;
    logic signed [33:0] mag;

    // Track samples accepted but not yet delivered.
    always_ff @(posedge clk) begin
        if (!rst_n) inflight <= '0;
        else        inflight <= inflight + 8'(in_valid) - 8'(out_valid);
    end

    // Sum of squares of the output pair.
    always_comb mag = 34'(out_sin * out_sin) + 34'(out_cos * out_cos);

    generate
        if (BANKS > 0) begin : g_seq_chk
            // R1: reset leaves no result on the output.
            a_r1_reset_clears: assert property (@(posedge clk)
                !rst_n |=> !out_valid);
            // R3: never more samples in flight than there are banks.
            a_r3_inflight_bound: assert property (@(posedge clk) disable iff (!rst_n)
                inflight <= 8'(BANKS));
        end
    endgenerate

    // R6: the output vector keeps unit magnitude.
    a_r6_magnitude: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (mag > 34'sd267386880 && mag < 34'sd269484032));
    // R4: the sine stays within full scale plus tolerance.
    a_r4_sin_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_sin <= 16'sd16400 && out_sin >= -16'sd16400));
    // R5: the cosine is never meaningfully negative inside +/-pi/2.
    a_r5_cos_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_cos >= -16'sd16 && out_cos <= 16'sd16400));
endmodule

// File: tb/sim_cordic_sine_unrolled.sv
`timescale 1ns/1ps
module sim_cordic_sine_unrolled;
    localparam int ITER = 14;
    localparam int SPR  = 1;
    localparam int LAT  = (SPR > ITER) ? 0 : (ITER + SPR - 1) / SPR;
    localparam int TOL  = 10;
    localparam int HMAX = 8192;
    localparam real PI  = 3.14159265358979;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               in_valid;
    logic signed [15:0] in_angle;
    logic               out_valid;
    logic signed [15:0] out_sin;
    logic signed [15:0] out_cos;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 0;

    bit               hist_v [0:HMAX-1];
    logic signed [15:0] hist_a [0:HMAX-1];

    always #2 clk = ~clk;

    cordic_sine_unrolled #(.ITER(ITER), .STAGES_PER_REG(SPR)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_angle(in_angle),
        .out_valid(out_valid), .out_sin(out_sin), .out_cos(out_cos)
    );

    function automatic int ref_val(input logic signed [15:0] a, input bit want_sin);
        real th = real'(a) * PI / 32768.0;
        real v  = want_sin ? $sin(th) : $cos(th);
        return $rtoi($floor(v * 16384.0 + 0.5));
    endfunction

    task automatic check_out();
        bit ev;
        ev = (cyc >= LAT) ? hist_v[cyc - LAT] : 1'b0;
        checks++;
        if (out_valid !== ev) begin
            errors++;
            $display("FAIL R3 cycle %0d out_valid actual=%0b expected=%0b", cyc, out_valid, ev);
        end
        if (ev && out_valid === 1'b1) begin
            int es, ec, m;
            es = ref_val(hist_a[cyc - LAT], 1'b1);
            ec = ref_val(hist_a[cyc - LAT], 1'b0);
            checks++;
            if (int'(out_sin) > es + TOL || int'(out_sin) < es - TOL) begin
                errors++;
                $display("FAIL R4 angle %0d sin actual=%0d expected=%0d", hist_a[cyc-LAT], out_sin, es);
            end
            checks++;
            if (int'(out_cos) > ec + TOL || int'(out_cos) < ec - TOL) begin
                errors++;
                $display("FAIL R5 angle %0d cos actual=%0d expected=%0d", hist_a[cyc-LAT], out_cos, ec);
            end
            m = int'(out_sin) * int'(out_sin) + int'(out_cos) * int'(out_cos);
            checks++;
            if (m <= 268435456 - 1048576 || m >= 268435456 + 1048576) begin
                errors++;
                $display("FAIL R6 magnitude actual=%0d expected=%0d", m, 268435456);
            end
        end
    endtask

    // One bench cycle: drive on the falling edge, record, then check.
    task automatic step(input bit v, input logic signed [15:0] a, input bit r);
        @(negedge clk);
        rst_n    = r;
        in_valid = v;
        in_angle = a;
        hist_v[cyc] = v && (r || LAT == 0);
        hist_a[cyc] = a;
        if (!r && LAT > 0)
            for (int k = cyc - LAT + 1; k < cyc; k++)
                if (k >= 0) hist_v[k] = 1'b0;   // R1: reset drops samples in flight
        #1;
        check_out();
        cyc++;
    endtask

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_angle = '0;
        void'($urandom(32'd20240611));
        // R1: strobes during reset produce nothing.
        for (int i = 0; i < 4; i++) step(1'b1, 16'sd1000, 1'b0);
        // R7 and R2: directed corners, back to back.
        step(1'b1,  16'sd16384, 1'b1);
        step(1'b1, -16'sd16384, 1'b1);
        step(1'b1,  16'sd0,     1'b1);
        step(1'b1,  16'sd8192,  1'b1);
        step(1'b1, -16'sd8192,  1'b1);
        step(1'b1,  16'sd1,     1'b1);
        step(1'b1, -16'sd1,     1'b1);
        step(1'b1,  16'sd16383, 1'b1);
        // R2: continuous random stream.
        for (int i = 0; i < 600; i++)
            step(1'b1, 16'(int'($urandom_range(32768, 0)) - 16384), 1'b1);
        // R3: random gaps in the strobe.
        for (int i = 0; i < 1500; i++)
            step(($urandom_range(3, 0) != 0), 16'(int'($urandom_range(32768, 0)) - 16384), 1'b1);
        // R1: reset while the pipeline is full and the strobe high.
        step(1'b1, 16'sd4000, 1'b0);
        step(1'b1, 16'sd4000, 1'b0);
        for (int i = 0; i < 200; i++)
            step(1'b1, 16'(int'($urandom_range(32768, 0)) - 16384), 1'b1);
        for (int i = 0; i < LAT + 2; i++) step(1'b0, 16'sd0, 1'b1);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule